// File: doc/BRIEF.md
# Strided Vector Load Sequencer

This block turns one scalar load whose destination is a vectorised register into a run of element loads. Element `i` is read from memory and written to register `dst + i`. The number of elements comes from the command's vector length. A length of zero counts as one element, which is the scalar default. Each load starts from the base register's value. Its step is one of two kinds: the element size (4 bytes, unit stride), or the load's signed immediate used as a per-element stride.

The choice of step comes from a small table of two offset slots. A set-offset command binds a slot to a register number and a bank (integer or floating point). It also gives the slot a stride mode and an offset amount. When a load's base register matches an integer-bank slot, that slot's amount is added to the start address and its mode picks the stride. When both slots match, slot 0 takes precedence. With no match, the sequence uses unit stride with no added offset.

Commands arrive on a valid/ready port. The block holds one sequence at a time, so `cmd_ready` is high only while it is idle. The memory read request is valid/ready: `mem_req_valid` and `mem_req_addr` stay fixed until `mem_req_ready` is seen. The read response is valid/ready, and the block takes data only while waiting for it. The register write is valid/ready: `wr_valid`, `wr_idx` and `wr_data` stay fixed until `wr_ready`. `done` and `err` are plain one-cycle status pulses.

Top module: `vload_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `mem_req_valid`, `wr_valid`, `done` and `err` are 0.
- R2: With no matching slot, element i is read from `cmd_base_val + 4*i` and written to register `cmd_dst + i`, and the write data equals the read data.
- R3: When the base register matches a slot in offset mode (`cfg_stride_mode` = 1), element i is read from `cmd_base_val + amount + i*imm`, where `imm` is `cmd_imm` sign-extended from 12 bits.
- R4: When the base register matches a slot in unit mode (`cfg_stride_mode` = 0), element i is read from `cmd_base_val + amount + 4*i`.
- R5: When both slots match the base register, slot 0 (`cfg_slot` = 0) supplies the amount and mode.
- R6: A slot programmed with `cfg_fp` = 1 never matches a load's base register.
- R7: A `cmd_vlen` of 0 produces exactly one element.
- R8: At most one read is outstanding at a time. The next request is issued only after the previous element's write has been accepted. A request held back by `mem_req_ready` = 0 keeps its address unchanged.
- R9: While a sequence runs, `cmd_ready` is 0 and any command presented then is ignored.
- R10: `done` is high for exactly one cycle, in the cycle after the last write handshake.
- R11: If `cmd_dst + max(cmd_vlen,1) - 1` exceeds 31, the command is accepted. It issues no read and no write and gives no `done`, and `err` pulses for one cycle.
- R12: A sequence uses the slot contents it sees when the command is accepted. A set-offset command in the same cycle, or during the run, affects only later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Set-offset command strobe |
| cfg_slot | input | 1 | Slot index written |
| cfg_reg | input | 5 | Register number bound to the slot |
| cfg_fp | input | 1 | Bank: 1 = floating point, 0 = integer |
| cfg_stride_mode | input | 1 | 1 = immediate is stride, 0 = unit stride |
| cfg_amount | input | 32 | Offset amount (value of the source register) |
| cmd_valid | input | 1 | Load command valid |
| cmd_ready | output | 1 | Load command ready (idle) |
| cmd_dst | input | 5 | First destination register |
| cmd_base_reg | input | 5 | Base register number |
| cmd_base_val | input | 32 | Base register value |
| cmd_imm | input | 12 | Signed immediate |
| cmd_vlen | input | 6 | Element count (0 means 1) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request ready |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Read data ready |
| mem_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write ready |
| wr_idx | output | 5 | Register written |
| wr_data | output | 32 | Data written |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle range-error pulse |

## Verification
A set-offset command and the acceptance of a load can fall in the same clock edge. When both touch the slot the load looks up, the outcome depends on which wins. The bench programs a slot for the load's base register in the very cycle the load is presented. It then checks that the address series is the unit-stride one built from the old table. A second load afterwards must show the new offset. The bench also rewrites the slot in the middle of a running sequence. It then checks that the remaining addresses keep the stride latched at acceptance.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WR
  } seq_state_e;
endpackage

// File: rtl/vload_offset_table.sv
module vload_offset_table #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int NSLOT  = 2,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [RIDX_W-1:0] cfg_reg,
  input  logic              cfg_fp,
  input  logic              cfg_stride_mode,
  input  logic [XLEN-1:0]   cfg_amount,
  input  logic [RIDX_W-1:0] lk_reg,
  output logic              lk_hit,
  output logic              lk_stride_mode,
  output logic [XLEN-1:0]   lk_amount
);
  logic              used_q [NSLOT];
  logic [RIDX_W-1:0] reg_q  [NSLOT];
  logic              fp_q   [NSLOT];
  logic              mode_q [NSLOT];
  logic [XLEN-1:0]   amt_q  [NSLOT];
  logic [NSLOT-1:0]  match;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[s] <= 1'b0;
        reg_q[s]  <= '0;
        fp_q[s]   <= 1'b0;
        mode_q[s] <= 1'b0;
        amt_q[s]  <= '0;
      end else if (cfg_valid && (cfg_slot == SLOT_W'(s))) begin
        used_q[s] <= 1'b1;
        reg_q[s]  <= cfg_reg;
        fp_q[s]   <= cfg_fp;
        mode_q[s] <= cfg_stride_mode;
        amt_q[s]  <= cfg_amount;
      end
    end
    // only integer-bank slots can bind a load's base register
    assign match[s] = used_q[s] && !fp_q[s] && (reg_q[s] == lk_reg);
  end

  // lowest slot index wins: scan from the top so lower slots overwrite
  always_comb begin
    lk_hit         = 1'b0;
    lk_stride_mode = 1'b0;
    lk_amount      = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (match[s]) begin
        lk_hit         = 1'b1;
        lk_stride_mode = mode_q[s];
        lk_amount      = amt_q[s];
      end
    end
  end
endmodule

// File: rtl/vload_addr_gen.sv
module vload_addr_gen #(
  parameter int XLEN       = 32,
  parameter int IMM_W      = 12,
  parameter int ELEM_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [XLEN-1:0]  base,
  input  logic             hit,
  input  logic             stride_mode,
  input  logic [XLEN-1:0]  amount,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  addr
);
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] stride_q;
  logic [XLEN-1:0] stride_d;
  logic [XLEN-1:0] first_d;

  always_comb begin
    if (hit && stride_mode) stride_d = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    else                    stride_d = XLEN'(ELEM_BYTES);
    first_d = base + (hit ? amount : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (start) begin
      addr_q   <= first_d;
      stride_q <= stride_d;
    end else if (step) begin
      addr_q <= addr_q + stride_q;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/vload_ctrl.sv
module vload_ctrl
  import vload_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int VLEN_W = 6,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [RIDX_W-1:0] cmd_dst,
  input  logic [VLEN_W-1:0] cmd_vlen,
  output logic              start,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              step,
  output logic              done,
  output logic              err
);
  localparam int SUM_W = ((RIDX_W > VLEN_W) ? RIDX_W : VLEN_W) + 1;

  seq_state_e        state_q;
  logic [VLEN_W-1:0] rem_q;
  logic [RIDX_W-1:0] idx_q;
  logic [XLEN-1:0]   data_q;
  logic              done_q;
  logic              err_q;
  logic [VLEN_W-1:0] eff_vlen;
  logic [SUM_W-1:0]  last_idx;
  logic              range_bad;
  logic              accept;

  always_comb begin
    eff_vlen  = (cmd_vlen == '0) ? VLEN_W'(1) : cmd_vlen;
    last_idx  = SUM_W'(cmd_dst) + SUM_W'(eff_vlen) - SUM_W'(1);
    range_bad = last_idx > SUM_W'(NREG - 1);
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign start         = accept && !range_bad;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign wr_valid      = (state_q == ST_WR);
  assign step          = (state_q == ST_WR) && wr_ready;
  assign wr_idx        = idx_q;
  assign wr_data       = data_q;
  assign done          = done_q;
  assign err           = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= accept && range_bad;
      unique case (state_q)
        ST_IDLE: if (start) begin
          rem_q   <= eff_vlen - VLEN_W'(1);
          idx_q   <= cmd_dst;
          state_q <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          data_q  <= mem_rsp_data;
          state_q <= ST_WR;
        end
        ST_WR: if (wr_ready) begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rem_q   <= rem_q - VLEN_W'(1);
            idx_q   <= idx_q + RIDX_W'(1);
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vload_seq.sv
module vload_seq #(
  parameter int XLEN       = 32,
  parameter int RIDX_W     = 5,
  parameter int VLEN_W     = 6,
  parameter int IMM_W      = 12,
  parameter int NSLOT      = 2,
  parameter int ELEM_BYTES = 4,
  localparam int NREG      = 1 << RIDX_W,
  localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [RIDX_W-1:0] cfg_reg,
  input  logic              cfg_fp,
  input  logic              cfg_stride_mode,
  input  logic [XLEN-1:0]   cfg_amount,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [RIDX_W-1:0] cmd_dst,
  input  logic [RIDX_W-1:0] cmd_base_reg,
  input  logic [XLEN-1:0]   cmd_base_val,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [VLEN_W-1:0] cmd_vlen,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              done,
  output logic              err
);
  logic            lk_hit;
  logic            lk_mode;
  logic [XLEN-1:0] lk_amount;
  logic            start;
  logic            step;

  vload_offset_table #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg),
    .cfg_fp(cfg_fp), .cfg_stride_mode(cfg_stride_mode), .cfg_amount(cfg_amount),
    .lk_reg(cmd_base_reg), .lk_hit(lk_hit), .lk_stride_mode(lk_mode),
    .lk_amount(lk_amount)
  );

  vload_addr_gen #(
    .XLEN(XLEN), .IMM_W(IMM_W), .ELEM_BYTES(ELEM_BYTES)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .base(cmd_base_val), .hit(lk_hit), .stride_mode(lk_mode),
    .amount(lk_amount), .imm(cmd_imm), .addr(mem_req_addr)
  );

  vload_ctrl #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .VLEN_W(VLEN_W), .NREG(NREG)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dst(cmd_dst),
    .cmd_vlen(cmd_vlen), .start(start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_data(wr_data), .step(step), .done(done), .err(err)
  );
endmodule

// File: rtl/vload_seq_chk.sv
module vload_seq_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [RIDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]   wr_data,
  input logic              done,
  input logic              err
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, mem_rsp_ready, wr_valid}));

  a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_data));

  a_r9_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready || wr_valid) |-> !cmd_ready);

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req_valid && !wr_valid && !done);

  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind vload_seq vload_seq_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .err(err)
);

// File: tb/sim_vload_seq.sv
module sim_vload_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [0:0]  cfg_slot = '0;
  logic [4:0]  cfg_reg = '0;
  logic        cfg_fp = 1'b0;
  logic        cfg_stride_mode = 1'b0;
  logic [31:0] cfg_amount = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [4:0]  cmd_dst = '0;
  logic [4:0]  cmd_base_reg = '0;
  logic [31:0] cmd_base_val = '0;
  logic [11:0] cmd_imm = '0;
  logic [5:0]  cmd_vlen = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        done;
  logic        err;

  always #2.5 clk = ~clk;

  vload_seq u0 (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  logic [31:0] addr_log [64];
  logic [4:0]  idx_log  [64];
  logic [31:0] data_log [64];
  int n_req = 0, n_wr = 0, done_cnt = 0, err_cnt = 0;
  int done_cyc = 0, last_wr_cyc = 0, overlap = 0, err_len = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory and register-file model; drives at the falling edge, logs handshakes
  initial begin : responder
    bit req_hs, rsp_hs, pending, outstanding;
    int delay;
    logic [31:0] pend_addr;
    req_hs = 0; rsp_hs = 0; pending = 0; outstanding = 0; delay = 0; pend_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_hs) begin mem_rsp_valid = 1'b0; rsp_hs = 0; end
      if (req_hs) begin pending = 1; delay = 2; req_hs = 0; end
      mem_req_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
      req_hs = mem_req_valid && mem_req_ready;
      if (req_hs) begin
        if (outstanding) overlap++;
        outstanding = 1;
        if (n_req < 64) addr_log[n_req] = mem_req_addr;
        n_req++;
        pend_addr = mem_req_addr;
      end
      if (pending) begin
        if (delay > 0) delay--;
        else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_word(pend_addr);
          pending = 0;
        end
      end
      rsp_hs = mem_rsp_valid && mem_rsp_ready;
      wr_ready = stall_en ? ((cyc % 2) == 0) : 1'b1;
      if (wr_valid && wr_ready) begin
        if (n_wr < 64) begin idx_log[n_wr] = wr_idx; data_log[n_wr] = wr_data; end
        n_wr++;
        last_wr_cyc = cyc;
        outstanding = 0;
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (err) begin err_cnt++; err_len++; end
    end
  end

  task automatic clear_logs();
    n_req = 0; n_wr = 0; done_cnt = 0; err_cnt = 0; err_len = 0; overlap = 0;
  endtask

  task automatic program_slot(input logic s, input logic [4:0] r, input logic fp,
                              input logic mode, input logic [31:0] amt);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_slot = s; cfg_reg = r; cfg_fp = fp;
    cfg_stride_mode = mode; cfg_amount = amt;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic present_cmd(input logic [4:0] dst, input logic [4:0] breg,
                             input logic [31:0] bval, input logic [11:0] imm, input logic [5:0] vl);
    cmd_valid = 1'b1; cmd_dst = dst; cmd_base_reg = breg; cmd_base_val = bval;
    cmd_imm = imm; cmd_vlen = vl;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done_cnt != 0 || err_cnt != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_load(input logic [4:0] dst, input logic [4:0] breg,
                          input logic [31:0] bval, input logic [11:0] imm, input logic [5:0] vl);
    clear_logs();
    @(negedge clk);
    present_cmd(dst, breg, bval, imm, vl);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_end();
  endtask

  task automatic expect_seq(input string tag, input int n, input logic [31:0] a0,
                            input logic [31:0] stride, input int dst);
    chk(n_req == n, {tag, " request count"}, n_req, n);
    chk(n_wr == n, {tag, " write count"}, n_wr, n);
    for (int i = 0; i < n && i < 64; i++) begin
      logic [31:0] ea;
      ea = a0 + stride * i;
      chk(addr_log[i] == ea, {tag, " address"}, addr_log[i], ea);
      chk(idx_log[i] == 5'(dst + i), {tag, " R2 write index"}, 32'(idx_log[i]), dst + i);
      chk(data_log[i] == mem_word(ea), {tag, " R2 write data"}, data_log[i], mem_word(ea));
    end
    chk(done_cnt == 1, {tag, " R10 done count"}, done_cnt, 1);
    chk(done_cyc == last_wr_cyc + 1, {tag, " R10 done timing"}, done_cyc, last_wr_cyc + 1);
    chk(overlap == 0, {tag, " R8 outstanding"}, overlap, 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(!mem_req_valid && !wr_valid, "R1 idle outputs", {mem_req_valid, wr_valid}, 0);
    chk(!done && !err, "R1 pulses", {done, err}, 0);
  endtask

  task automatic t_unit_nomatch();
    stall_en = 1'b1;
    run_load(5'd4, 5'd2, 32'h1000, 12'd12, 6'd3);
    expect_seq("R2 unit no-match", 3, 32'h1000, 32'd4, 4);
    stall_en = 1'b0;
  endtask

  task automatic t_offset_mode();
    program_slot(1'b1, 5'd7, 1'b0, 1'b1, 32'h40);
    run_load(5'd10, 5'd7, 32'h2000, 12'd12, 6'd4);
    expect_seq("R3 offset stride", 4, 32'h2040, 32'd12, 10);
    run_load(5'd12, 5'd7, 32'h2000, 12'hFF8, 6'd2);
    expect_seq("R3 negative stride", 2, 32'h2040, 32'hFFFF_FFF8, 12);
  endtask

  task automatic t_unit_match();
    program_slot(1'b0, 5'd9, 1'b0, 1'b0, 32'h10);
    run_load(5'd1, 5'd9, 32'h3000, 12'd100, 6'd2);
    expect_seq("R4 unit with offset", 2, 32'h3010, 32'd4, 1);
  endtask

  task automatic t_priority();
    program_slot(1'b0, 5'd7, 1'b0, 1'b0, 32'h8);
    run_load(5'd20, 5'd7, 32'h2000, 12'd12, 6'd2);
    expect_seq("R5 slot0 priority", 2, 32'h2008, 32'd4, 20);
  endtask

  task automatic t_fp_bank();
    program_slot(1'b0, 5'd3, 1'b1, 1'b1, 32'h100);
    run_load(5'd6, 5'd3, 32'h500, 12'd20, 6'd2);
    expect_seq("R6 fp bank ignored", 2, 32'h500, 32'd4, 6);
  endtask

  task automatic t_vlen_zero();
    run_load(5'd31, 5'd2, 32'h700, 12'd0, 6'd0);
    expect_seq("R7 vlen zero", 1, 32'h700, 32'd4, 31);
    run_load(5'd30, 5'd2, 32'h800, 12'd0, 6'd2);
    expect_seq("R11 top boundary ok", 2, 32'h800, 32'd4, 30);
  endtask

  task automatic t_range_err();
    run_load(5'd30, 5'd2, 32'h900, 12'd0, 6'd3);
    chk(err_cnt == 1 && err_len == 1, "R11 err pulse", err_len, 1);
    chk(n_req == 0 && n_wr == 0, "R11 no access", n_req + n_wr, 0);
    chk(done_cnt == 0, "R11 no done", done_cnt, 0);
    chk(cmd_ready == 1'b1, "R11 back to idle", cmd_ready, 1);
  endtask

  task automatic t_busy();
    int refused;
    refused = 0;
    stall_en = 1'b1;
    clear_logs();
    @(negedge clk);
    present_cmd(5'd16, 5'd2, 32'hA000, 12'd0, 6'd4);
    @(negedge clk);
    present_cmd(5'd0, 5'd2, 32'hB000, 12'd0, 6'd1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!cmd_ready) refused++;
    end
    cmd_valid = 1'b0;
    chk(refused == 6, "R9 ready low while busy", refused, 6);
    wait_end();
    expect_seq("R9 extra command ignored", 4, 32'hA000, 32'd4, 16);
    stall_en = 1'b0;
  endtask

  task automatic t_same_cycle_cfg();
    clear_logs();
    @(negedge clk);
    cfg_valid = 1'b1; cfg_slot = 1'b1; cfg_reg = 5'd11; cfg_fp = 1'b0;
    cfg_stride_mode = 1'b1; cfg_amount = 32'h100;
    present_cmd(5'd2, 5'd11, 32'hC000, 12'd16, 6'd2);
    @(negedge clk);
    cfg_valid = 1'b0; cmd_valid = 1'b0;
    wait_end();
    expect_seq("R12 same-cycle uses old table", 2, 32'hC000, 32'd4, 2);
    run_load(5'd2, 5'd11, 32'hC000, 12'd16, 6'd2);
    expect_seq("R12 later load sees new slot", 2, 32'hC100, 32'd16, 2);
    // reprogram the slot while a sequence is running
    stall_en = 1'b1;
    clear_logs();
    @(negedge clk);
    present_cmd(5'd8, 5'd11, 32'hD000, 12'd16, 6'd4);
    @(negedge clk);
    cmd_valid = 1'b0;
    cfg_valid = 1'b1; cfg_slot = 1'b1; cfg_reg = 5'd11; cfg_stride_mode = 1'b0;
    cfg_amount = 32'h0;
    @(negedge clk);
    cfg_valid = 1'b0;
    wait_end();
    expect_seq("R12 mid-run cfg no effect", 4, 32'hD100, 32'd16, 8);
    stall_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_unit_nomatch();
    t_offset_mode();
    t_unit_match();
    t_priority();
    t_fp_bank();
    t_vlen_zero();
    t_range_err();
    t_busy();
    t_same_cycle_cfg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule